// File: doc/BRIEF.md
# OTG Port Interrupt and Status Unit

This unit collects the interrupt-relevant activity of a dual-role USB port and presents it to software through three 32-bit registers on a simple register bus. It samples five analog-comparator and pin levels (ID, session end, B-session valid, A-session valid, VBUS valid). A change on any of them, in either direction, raises a sticky flag. Single-cycle event pulses from the role state machine land in sticky flags of their own. Each flag has an enable bit at the same position, and one interrupt line is driven from the enabled flags.

Software clears a flag by writing a one to its position. Clearing the VBUS-error flag also returns a one-cycle recovery pulse to the role state machine. The unit also adapts the external VBUS power switch to the board: the enable output and the status input each have a polarity select, so the state machine always works with active-high signals.

Top module: `otg_irq_unit`

## Requirements
- R1: After reset all flags and enables read zero, `irq_o` and `recover_o` are low.
- R2: Byte offset 0x08 reads and writes the enable register, 0x0C the flag register and 0x10 the read-only live status. Any other offset reads zero and ignores writes. Enable and flag bit 12 and bits 31:14 read zero, and live bits 31:8 read zero.
- R3: A write to 0x0C clears every flag whose data bit is 1 and leaves flags whose data bit is 0 untouched.
- R4: When a hardware set and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R5: Event input bits map to flag positions as follows: `evt_i[0]`→0 role change, [1]→1 VBUS error, [2]→2 SRP fail, [3]→3 HNP fail, [4]→4 go idle, [5]→6 peripheral, [6]→7 host, [7]→13 SRP detected. A pulse high at a clock edge sets the flag at that edge.
- R6: Change flags are: ID→5, B-valid→8, A-valid→9, VBUS-valid→10, session end→11. Each one is set at the edge where a new level of its input, rising or falling, is first sampled.
- R7: The first sample taken after reset sets no change flag, whatever the input levels are.
- R8: Live status at 0x10 holds bit 0 over-current, 1 ID, 2 session end, 3 B-valid, 4 A-valid, 5 VBUS valid, 6 as peripheral, 7 as host. Each bit shows its input as sampled at the previous clock edge.
- R9: `irq_o` is high exactly when some flag and its enable bit are both 1.
- R10: `recover_o` is high for the one cycle after each write to 0x0C that has data bit 1 set.
- R11: `vbus_sw_en_o` equals `vbus_drive_i` when `pol_en_i` is 0 and its inverse when `pol_en_i` is 1.
- R12: `vbus_sw_ok_o` equals `vbus_sw_st_i` when `pol_st_i` is 0 and its inverse when `pol_st_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| evt_i | input | 8 | Event pulses from the role state machine |
| id_i | input | 1 | ID pin level |
| sess_end_i | input | 1 | Session-end comparator |
| b_valid_i | input | 1 | B-session valid comparator |
| a_valid_i | input | 1 | A-session valid comparator |
| vbus_valid_i | input | 1 | VBUS valid comparator |
| over_cur_i | input | 1 | Over-current level from the state machine |
| as_periph_i | input | 1 | Port acts as peripheral |
| as_host_i | input | 1 | Port acts as host |
| vbus_drive_i | input | 1 | Active-high VBUS drive request |
| pol_en_i | input | 1 | Switch enable polarity, 1 = active low |
| vbus_sw_en_o | output | 1 | External power switch enable pin |
| vbus_sw_st_i | input | 1 | External power switch status pin |
| pol_st_i | input | 1 | Switch status polarity, 1 = active low |
| vbus_sw_ok_o | output | 1 | Active-high switch status to the state machine |
| irq_o | output | 1 | Interrupt request |
| recover_o | output | 1 | VBUS-error recovery pulse |

## Verification
Read data and both switch pins are combinational, so they are due in the same cycle as their inputs. Flags, enables, live status and the recovery pulse appear one edge after the stimulus. `irq_o` follows the registered flags and enables and is therefore also due one edge later. The bench drives every input on the falling edge and compares the combinational outputs 1 ns later. It then advances its reference model across the rising edge and compares the registered results at the next falling edge. Directed cases cover priming, each edge direction, the set-versus-clear collision and the recovery pulse.

// File: rtl/otg_irq_pkg.sv
package otg_irq_pkg;
  localparam int FLAG_W = 14;
  localparam int LIVE_W = 8;
  localparam int EVT_W  = 8;
  localparam int MON_W  = 5;

  localparam int F_VBERR = 1;

  // flag 12 reserved
  localparam logic [FLAG_W-1:0] FLAG_MASK = 14'h2FFF;

  // event input index -> flag position
  localparam int EVT_POS [EVT_W] = '{0, 1, 2, 3, 4, 6, 7, 13};
  // monitor index (id, sess_end, b_valid, a_valid, vbus_valid) -> flag position
  localparam int MON_POS [MON_W] = '{5, 11, 8, 9, 10};
endpackage

// File: rtl/otg_edge_mon.sv
module otg_edge_mon #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] smp_o,
  output logic [N-1:0] chg_o,
  output logic         primed_o
);
  logic primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end
  assign primed_o = primed_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic smp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) smp_q <= 1'b0;
      else         smp_q <= sig_i[g];
    end
    assign smp_o[g] = smp_q;
    // first sample after reset only loads the history
    assign chg_o[g] = primed_q & (sig_i[g] ^ smp_q);
  end
endmodule

// File: rtl/otg_flag_bank.sv
module otg_flag_bank #(
  parameter int           W    = 14,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^((set_i | clr_i) & ~MASK);

  for (genvar g = 0; g < W; g++) begin : g_flag
    if (MASK[g]) begin : g_live
      logic flag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= set_i[g] | (flag_q & ~clr_i[g]); // set wins
      end
      assign flag_o[g] = flag_q;
    end else begin : g_rsvd
      assign flag_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/otg_vbus_pol.sv
module otg_vbus_pol (
  input  logic drive_i,
  input  logic pol_en_i,
  output logic sw_en_o,
  input  logic sw_st_i,
  input  logic pol_st_i,
  output logic sw_ok_o
);
  assign sw_en_o = pol_en_i ? ~drive_i : drive_i;
  assign sw_ok_o = pol_st_i ? ~sw_st_i : sw_st_i;
endmodule

// File: rtl/otg_irq_unit.sv
module otg_irq_unit
  import otg_irq_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] OFS_EN   = 'h08,
  parameter logic [ADDR_W-1:0] OFS_FLAG = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_LIVE = 'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              id_i,
  input  logic              sess_end_i,
  input  logic              b_valid_i,
  input  logic              a_valid_i,
  input  logic              vbus_valid_i,
  input  logic              over_cur_i,
  input  logic              as_periph_i,
  input  logic              as_host_i,
  input  logic              vbus_drive_i,
  input  logic              pol_en_i,
  output logic              vbus_sw_en_o,
  input  logic              vbus_sw_st_i,
  input  logic              pol_st_i,
  output logic              vbus_sw_ok_o,
  output logic              irq_o,
  output logic              recover_o
);
  logic [MON_W-1:0]  mon_raw, mon_smp, mon_chg;
  logic              mon_primed;
  logic [2:0]        lvl_q;
  logic [LIVE_W-1:0] live_q;
  logic [FLAG_W-1:0] hw_set, sw_clr, flag_q, en_q;
  logic              wr_en, wr_flag, rec_q;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata_i[DATA_W-1:FLAG_W];

  assign wr_en   = bus_we_i && (bus_addr_i == OFS_EN);
  assign wr_flag = bus_we_i && (bus_addr_i == OFS_FLAG);

  assign mon_raw = {vbus_valid_i, a_valid_i, b_valid_i, sess_end_i, id_i};

  otg_edge_mon #(.N(MON_W)) u_mon (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sig_i   (mon_raw),
    .smp_o   (mon_smp),
    .chg_o   (mon_chg),
    .primed_o(mon_primed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= {as_host_i, as_periph_i, over_cur_i};
  end

  assign live_q = {lvl_q[2], lvl_q[1], mon_smp, lvl_q[0]};

  always_comb begin
    hw_set = '0;
    for (int i = 0; i < EVT_W; i++) hw_set[EVT_POS[i]] = hw_set[EVT_POS[i]] | evt_i[i];
    for (int i = 0; i < MON_W; i++) hw_set[MON_POS[i]] = hw_set[MON_POS[i]] | mon_chg[i];
  end

  assign sw_clr = wr_flag ? bus_wdata_i[FLAG_W-1:0] : '0;

  otg_flag_bank #(.W(FLAG_W), .MASK(FLAG_MASK)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (hw_set),
    .clr_i (sw_clr),
    .flag_o(flag_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      rec_q <= 1'b0;
    end else begin
      if (wr_en) en_q <= bus_wdata_i[FLAG_W-1:0] & FLAG_MASK;
      rec_q <= wr_flag & bus_wdata_i[F_VBERR];
    end
  end

  assign recover_o = rec_q;
  assign irq_o     = |(flag_q & en_q);

  always_comb begin
    bus_rdata_o = '0;
    if      (bus_addr_i == OFS_EN)   bus_rdata_o = DATA_W'(en_q);
    else if (bus_addr_i == OFS_FLAG) bus_rdata_o = DATA_W'(flag_q);
    else if (bus_addr_i == OFS_LIVE) bus_rdata_o = DATA_W'(live_q);
  end

  otg_vbus_pol u_pol (
    .drive_i (vbus_drive_i),
    .pol_en_i(pol_en_i),
    .sw_en_o (vbus_sw_en_o),
    .sw_st_i (vbus_sw_st_i),
    .pol_st_i(pol_st_i),
    .sw_ok_o (vbus_sw_ok_o)
  );
endmodule

// File: rtl/otg_irq_unit_chk.sv
module otg_irq_unit_chk #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter int                FLAG_W   = 14,
  parameter logic [ADDR_W-1:0] OFS_FLAG = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_LIVE = 'h10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [7:0]        evt_i,
  input logic              id_i,
  input logic              live_id,
  input logic [FLAG_W-1:0] flag_q,
  input logic [FLAG_W-1:0] hw_set,
  input logic              mon_primed,
  input logic              irq_o,
  input logic              recover_o,
  input logic              vbus_drive_i,
  input logic              pol_en_i,
  input logic              vbus_sw_en_o,
  input logic              vbus_sw_st_i,
  input logic              pol_st_i,
  input logic              vbus_sw_ok_o
);
  logic unused_chk;
  assign unused_chk = ^{bus_wdata_i, bus_rdata_o, evt_i};

  logic wr_flag;
  assign wr_flag = bus_we_i && (bus_addr_i == OFS_FLAG);

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFS_FLAG) |-> (bus_rdata_o[DATA_W-1:FLAG_W] == '0) && !bus_rdata_o[12]); // R2

  AST_W1C_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_flag |=> (flag_q & $past(bus_wdata_i[FLAG_W-1:0] & ~hw_set)) == '0); // R3

  AST_W0_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_flag |=> (flag_q & $past(flag_q & ~bus_wdata_i[FLAG_W-1:0])) == $past(flag_q & ~bus_wdata_i[FLAG_W-1:0])); // R3

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_set) |=> (flag_q & $past(hw_set)) == $past(hw_set)); // R4

  AST_EVT_SRPDET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[7] |=> flag_q[13]); // R5

  AST_ID_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mon_primed) && (live_id != $past(live_id))) |-> flag_q[5]); // R6

  AST_NO_PRIME_CHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mon_primed) |-> (flag_q & 14'h0F20) == '0); // R7

  AST_LIVE_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mon_primed && bus_addr_i == OFS_LIVE) |-> bus_rdata_o[1] == $past(id_i)); // R8

  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(bus_we_i) || $past(|hw_set))); // R9

  AST_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o |-> $past(wr_flag && bus_wdata_i[1])); // R10

  AST_EN_POL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_en_i && vbus_drive_i) |-> !vbus_sw_en_o); // R11

  AST_ST_POL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_st_i && vbus_sw_st_i) |-> !vbus_sw_ok_o); // R12
endmodule

bind otg_irq_unit otg_irq_unit_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .FLAG_W  (otg_irq_pkg::FLAG_W),
  .OFS_FLAG(OFS_FLAG),
  .OFS_LIVE(OFS_LIVE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .evt_i       (evt_i),
  .id_i        (id_i),
  .live_id     (live_q[1]),
  .flag_q      (flag_q),
  .hw_set      (hw_set),
  .mon_primed  (mon_primed),
  .irq_o       (irq_o),
  .recover_o   (recover_o),
  .vbus_drive_i(vbus_drive_i),
  .pol_en_i    (pol_en_i),
  .vbus_sw_en_o(vbus_sw_en_o),
  .vbus_sw_st_i(vbus_sw_st_i),
  .pol_st_i    (pol_st_i),
  .vbus_sw_ok_o(vbus_sw_ok_o)
);

// File: tb/otg_irq_unit_tb_top.sv
`timescale 1ns/1ps
module otg_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [7:0]  evt;
  logic        id, se, bv, av, vv, oc, asp, ash;
  logic        drive, pol_en, sw_st, pol_st, sw_en, sw_ok, irq, rec;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [13:0] m_flag, m_en;
  logic [7:0]  m_live;
  logic        m_prime, m_rec;

  always #10 clk = ~clk;

  otg_irq_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_i(evt),
    .id_i(id), .sess_end_i(se), .b_valid_i(bv), .a_valid_i(av), .vbus_valid_i(vv),
    .over_cur_i(oc), .as_periph_i(asp), .as_host_i(ash),
    .vbus_drive_i(drive), .pol_en_i(pol_en), .vbus_sw_en_o(sw_en),
    .vbus_sw_st_i(sw_st), .pol_st_i(pol_st), .vbus_sw_ok_o(sw_ok),
    .irq_o(irq), .recover_o(rec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h08:   return {18'h0, m_en};
      8'h0C:   return {18'h0, m_flag};
      8'h10:   return {24'h0, m_live};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    case (a)
      8'h0C:   return "R3 flag read";
      8'h10:   return "R8 live read";
      default: return "R2 register read";
    endcase
  endfunction

  function automatic logic [13:0] hw_sets();
    logic [13:0] s = '0;
    s[0]  = evt[0]; s[1] = evt[1]; s[2] = evt[2]; s[3] = evt[3];
    s[4]  = evt[4]; s[6] = evt[5]; s[7] = evt[6]; s[13] = evt[7];
    if (m_prime) begin
      s[5]  = s[5]  | (id != m_live[1]);
      s[11] = s[11] | (se != m_live[2]);
      s[8]  = s[8]  | (bv != m_live[3]);
      s[9]  = s[9]  | (av != m_live[4]);
      s[10] = s[10] | (vv != m_live[5]);
    end
    return s;
  endfunction

  // inputs already driven at the falling edge
  task automatic step();
    logic [13:0] n_flag, n_en, clr;
    #1;
    check(read_tag(addr), rdata, exp_read(addr));
    check("R9 irq", {31'h0, irq}, {31'h0, |(m_flag & m_en)});
    check("R10 recover", {31'h0, rec}, {31'h0, m_rec});
    check("R11 switch enable", {31'h0, sw_en}, {31'h0, drive ^ pol_en});
    check("R12 switch status", {31'h0, sw_ok}, {31'h0, sw_st ^ pol_st});
    clr    = (we && addr == 8'h0C) ? wdata[13:0] : 14'h0;
    n_flag = ((m_flag & ~clr) | hw_sets()) & 14'h2FFF;
    n_en   = (we && addr == 8'h08) ? (wdata[13:0] & 14'h2FFF) : m_en;
    @(posedge clk);
    m_rec   = we && addr == 8'h0C && wdata[1];
    m_flag  = n_flag;
    m_en    = n_en;
    m_live  = {ash, asp, vv, av, bv, se, id, oc};
    m_prime = 1'b1;
    @(negedge clk);
    we = 0; evt = '0;
  endtask

  task automatic peek(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a; #1;
    check(tag, rdata, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a7c));
    rst_n = 0; we = 0; addr = 8'h0C; wdata = '0; evt = '0;
    id = 1; se = 0; bv = 0; av = 0; vv = 1; oc = 0; asp = 0; ash = 0;
    drive = 0; pol_en = 0; sw_st = 0; pol_st = 0;
    m_flag = '0; m_en = '0; m_live = '0; m_prime = 0; m_rec = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
    check("R1 recover after reset", {31'h0, rec}, 32'h0);
    peek("R1 flags after reset", 8'h0C, 32'h0);
    peek("R1 enables after reset", 8'h08, 32'h0);
    step();
    peek("R7 no change flag from first sample", 8'h0C, 32'h0);
    peek("R8 live after first sample", 8'h10, 32'h22);
    vv = 0; step();
    peek("R6 falling VBUS-valid sets bit 10", 8'h0C, 32'h400);
    id = 0; step();
    peek("R6 falling ID sets bit 5", 8'h0C, 32'h420);
    evt = 8'h80; step();
    peek("R5 SRP detected sets bit 13", 8'h0C, 32'h2420);
    addr = 8'h0C; we = 1; wdata = 32'h0; step();
    peek("R3 write of zero keeps flags", 8'h0C, 32'h2420);
    addr = 8'h0C; we = 1; wdata = 32'h2021; evt = 8'h01; step();
    peek("R4 set beats clear on bit 0", 8'h0C, 32'h401);
    addr = 8'h08; we = 1; wdata = 32'hFFFF_FFFF; step();
    peek("R2 enable reserved bits", 8'h08, 32'h2FFF);
    check("R9 irq with enabled flag", {31'h0, irq}, 32'h1);
    addr = 8'h14; we = 1; wdata = 32'hFFFF_FFFF; step();
    peek("R2 unmapped offset reads zero", 8'h14, 32'h0);
    peek("R2 unmapped write left flags", 8'h0C, 32'h401);
    addr = 8'h0C; we = 1; wdata = 32'h2; step();
    check("R10 recover pulse after write", {31'h0, rec}, 32'h1);
    step();
    check("R10 recover pulse ends", {31'h0, rec}, 32'h0);
    addr = 8'h0C; we = 1; wdata = 32'hFFFF_FFFF; step();
    check("R9 irq drops after clear", {31'h0, irq}, 32'h0);
    drive = 1; pol_en = 1; #1;
    check("R11 active-low enable", {31'h0, sw_en}, 32'h0);
    pol_en = 0; #1;
    check("R11 active-high enable", {31'h0, sw_en}, 32'h1);
    sw_st = 0; pol_st = 1; #1;
    check("R12 active-low status", {31'h0, sw_ok}, 32'h1);
    step();

    for (int i = 0; i < 4000; i++) begin
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 7));
      case (pick)
        0: addr = 8'h08; 1, 2: addr = 8'h0C; 3: addr = 8'h10;
        4: addr = 8'h00; 5: addr = 8'h04; default: addr = 8'($urandom);
      endcase
      we    = ($urandom_range(0, 3) == 0);
      wdata = $urandom & $urandom;
      evt   = 8'($urandom & $urandom & $urandom);
      if ($urandom_range(0, 7) == 0) id = ~id;
      if ($urandom_range(0, 7) == 0) se = ~se;
      if ($urandom_range(0, 7) == 0) bv = ~bv;
      if ($urandom_range(0, 7) == 0) av = ~av;
      if ($urandom_range(0, 7) == 0) vv = ~vv;
      oc = 1'($urandom); asp = 1'($urandom); ash = 1'($urandom);
      drive = 1'($urandom); pol_en = 1'($urandom);
      sw_st = 1'($urandom); pol_st = 1'($urandom);
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule